// File: doc/BRIEF.md
# Transmit FIFO Start Threshold Control

This block decides when a MAC transmitter may start draining the frame at the head of its transmit FIFO. It looks at how many bytes of the current frame are buffered and whether the frame's last byte has arrived. It then issues a single start pulse once enough data is present. The start point comes from a 2-bit threshold select, read through one of two byte tables. Which table applies depends on the link rate, 10 or 100 Mb/s. A store-and-forward setting overrides the tables and waits for the whole frame. A frame that is complete but shorter than the threshold still starts.

The threshold select, rate and store-and-forward inputs are captured when a new frame first appears in the FIFO. A change during the frame has no effect on that frame. After the start pulse, the FIFO might run dry before the frame's end has been consumed. If so, the block raises a sticky underflow flag and enters a suspended state. An explicit clear input releases both and re-arms the block for the next frame.

Top module: `tx_start_thresh`

## Requirements
- R1: After reset, `tx_start`, `tx_uflow` and `tx_susp` are all 0 and the block waits for a new frame.
- R2: At 100 Mb/s (`mode_10m`=0), select values 0, 1, 2 and 3 give thresholds of 128, 256, 512 and 1024 bytes.
- R3: At 10 Mb/s (`mode_10m`=1), select values 0, 1, 2 and 3 give thresholds of 72, 96, 128 and 160 bytes.
- R4: Without store-and-forward, a frame starts only when its buffered byte count is strictly greater than the threshold. A count equal to the threshold does not start it.
- R5: A frame whose end flag `frm_eof_in` is set starts even when its byte count is below the threshold.
- R6: When `sf_en` is captured as 1, the threshold select is ignored and the frame starts only once `frm_eof_in` is 1, whatever its byte count.
- R7: Each frame produces exactly one single-cycle `tx_start` pulse. The pulse comes the cycle after the start condition is seen on a frame already in progress. The block re-arms only after `eof_done` is seen while sending.
- R8: `thr_sel`, `mode_10m` and `sf_en` are captured on the cycle a new frame first appears (`frm_bytes` non-zero or `frm_eof_in` set). Changes after that do not affect the frame.
- R9: Suppose `fifo_empty` is 1 while the block is sending and `eof_done` is 0 in that cycle. Then `tx_uflow` and `tx_susp` both become 1 on the next cycle.
- R10: `tx_uflow` stays 1 until `uflow_clr` is 1. That same clear ends the suspended state and the block waits for a new frame.
- R11: No `tx_start` pulse is issued while `tx_susp` is 1, even if a frame meets its start condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_bytes | input | LEN_W | Bytes of the current frame held in the FIFO |
| frm_eof_in | input | 1 | Last byte of the current frame is in the FIFO |
| eof_done | input | 1 | Transmitter has consumed the frame's last byte |
| thr_sel | input | 2 | Threshold table select |
| mode_10m | input | 1 | 1 selects the 10 Mb/s table, 0 the 100 Mb/s table |
| sf_en | input | 1 | Store-and-forward enable |
| fifo_empty | input | 1 | Transmit FIFO holds no data |
| uflow_clr | input | 1 | Clears underflow and leaves suspension |
| tx_start | output | 1 | One-cycle start-transmit pulse |
| tx_uflow | output | 1 | Sticky underflow flag |
| tx_susp | output | 1 | Transmit process suspended |

## Verification
The bench runs every table entry at the exact threshold and one byte above it. A design using "greater or equal" would start a cycle early, and a design with a wrong table entry would start at the wrong count. It switches rate and select in the middle of a frame; a design that reads the live inputs would start against the new threshold. Store-and-forward frames far above every threshold catch a design that still consults the select. An underflow is followed by a frame that meets its start condition. This exposes a flag that is not sticky, or a start pulse issued while suspended.

// File: rtl/tx_thr_pkg.sv
package tx_thr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_SEND = 2'd2,
    ST_SUSP = 2'd3
  } thr_state_e;
endpackage

// File: rtl/tx_thr_cfg.sv
module tx_thr_cfg #(
  parameter int LEN_W        = 12,
  parameter int FAST_TBL [4] = '{128, 256, 512, 1024},
  parameter int SLOW_TBL [4] = '{72, 96, 128, 160}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             mode_10m,
  input  logic [1:0]       thr_sel,
  input  logic             sf_en,
  output logic [LEN_W-1:0] thr_q,
  output logic             sf_q
);
  localparam int NSEL = 4;

  logic [LEN_W-1:0] fast_v [NSEL];
  logic [LEN_W-1:0] slow_v [NSEL];
  logic [LEN_W-1:0] thr_d;

  for (genvar g = 0; g < NSEL; g++) begin : g_tbl
    assign fast_v[g] = LEN_W'(FAST_TBL[g]);
    assign slow_v[g] = LEN_W'(SLOW_TBL[g]);
  end

  always_comb begin
    thr_d = mode_10m ? slow_v[thr_sel] : fast_v[thr_sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= '0;
      sf_q  <= 1'b0;
    end else if (cap_en) begin
      thr_q <= thr_d;
      sf_q  <= sf_en;
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(thr_q) && $stable(sf_q)); // R8
endmodule

// File: rtl/tx_thr_cmp.sv
module tx_thr_cmp #(
  parameter int LEN_W = 12
) (
  input  logic [LEN_W-1:0] frm_bytes,
  input  logic             frm_eof_in,
  input  logic [LEN_W-1:0] thr,
  input  logic             sf,
  output logic             go
);
  logic above;

  always_comb begin
    above = (frm_bytes > thr);
    if (sf) go = frm_eof_in;
    else    go = frm_eof_in | above;
  end
endmodule

// File: rtl/tx_start_thresh.sv
module tx_start_thresh #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] frm_bytes,
  input  logic             frm_eof_in,
  input  logic             eof_done,
  input  logic [1:0]       thr_sel,
  input  logic             mode_10m,
  input  logic             sf_en,
  input  logic             fifo_empty,
  input  logic             uflow_clr,
  output logic             tx_start,
  output logic             tx_uflow,
  output logic             tx_susp
);
  import tx_thr_pkg::*;

  thr_state_e       st_q, st_d;
  logic             start_q, start_d;
  logic             uflow_q, uflow_d;
  logic             cap_en, go, frame_seen;
  logic [LEN_W-1:0] thr_q;
  logic             sf_q;

  assign frame_seen = (frm_bytes != '0) | frm_eof_in;
  assign cap_en     = (st_q == ST_IDLE) & frame_seen;

  tx_thr_cfg #(.LEN_W(LEN_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .mode_10m (mode_10m),
    .thr_sel  (thr_sel),
    .sf_en    (sf_en),
    .thr_q    (thr_q),
    .sf_q     (sf_q)
  );

  tx_thr_cmp #(.LEN_W(LEN_W)) u_cmp (
    .frm_bytes  (frm_bytes),
    .frm_eof_in (frm_eof_in),
    .thr        (thr_q),
    .sf         (sf_q),
    .go         (go)
  );

  always_comb begin
    st_d    = st_q;
    start_d = 1'b0;
    uflow_d = uflow_q & ~uflow_clr;
    unique case (st_q)
      ST_IDLE: if (frame_seen) st_d = ST_FILL;
      ST_FILL: if (go) begin
        st_d    = ST_SEND;
        start_d = 1'b1;
      end
      ST_SEND: begin
        if (eof_done) begin
          st_d = ST_IDLE;
        end else if (fifo_empty) begin
          st_d    = ST_SUSP;
          uflow_d = 1'b1;
        end
      end
      ST_SUSP: if (uflow_clr) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      start_q <= 1'b0;
      uflow_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= start_d;
      uflow_q <= uflow_d;
    end
  end

  assign tx_start = start_q;
  assign tx_uflow = uflow_q;
  assign tx_susp  = (st_q == ST_SUSP);

  AST_ONE_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start); // R7
  AST_UFLOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_uflow && !uflow_clr |=> tx_uflow); // R10
  AST_SUSP_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    tx_susp |-> !tx_start); // R11
  AST_UFLOW_AFTER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_uflow) |-> $past(fifo_empty)); // R9
  AST_SF_WAITS_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FILL) && sf_q && !frm_eof_in |=> !tx_start); // R6
  AST_NOT_AT_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FILL) && !sf_q && !frm_eof_in && (frm_bytes <= thr_q) |=> !tx_start); // R4
endmodule

// File: tb/tx_start_thresh_bench.sv
module tx_start_thresh_bench;
  localparam int LEN_W = 12;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [LEN_W-1:0] frm_bytes;
  logic             frm_eof_in, eof_done, mode_10m, sf_en, fifo_empty, uflow_clr;
  logic [1:0]       thr_sel;
  logic             tx_start, tx_uflow, tx_susp;

  int n_chk = 0;
  int n_fail = 0;
  int starts_seen = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  tx_start_thresh #(.LEN_W(LEN_W)) u_tx_start_thresh (
    .clk(clk), .rst_n(rst_n), .frm_bytes(frm_bytes), .frm_eof_in(frm_eof_in),
    .eof_done(eof_done), .thr_sel(thr_sel), .mode_10m(mode_10m), .sf_en(sf_en),
    .fifo_empty(fifo_empty), .uflow_clr(uflow_clr),
    .tx_start(tx_start), .tx_uflow(tx_uflow), .tx_susp(tx_susp)
  );

  // behavioural reference: 0 idle, 1 waiting for data, 2 sending, 3 suspended
  int m_ph;
  int m_thr;
  bit m_sf, m_start, m_uf;

  function automatic int table_bytes(bit slow, int sel);
    int fast_t [4] = '{128, 256, 512, 1024};
    int slow_t [4] = '{72, 96, 128, 160};
    return slow ? slow_t[sel] : fast_t[sel];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_thr = 0; m_sf = 0; m_start = 0; m_uf = 0;
    end else begin
      m_start = 0;
      if (uflow_clr) m_uf = 0;
      if (m_ph == 0) begin
        if (frm_bytes != 0 || frm_eof_in) begin
          m_thr = table_bytes(mode_10m, int'(thr_sel));
          m_sf  = sf_en;
          m_ph  = 1;
        end
      end else if (m_ph == 1) begin
        if (m_sf ? frm_eof_in : (frm_eof_in || int'(frm_bytes) > m_thr)) begin
          m_start = 1; m_ph = 2;
        end
      end else if (m_ph == 2) begin
        if (eof_done) m_ph = 0;
        else if (fifo_empty) begin m_ph = 3; m_uf = 1; end
      end else begin
        if (uflow_clr) m_ph = 0;
      end
    end
  end

  task automatic check(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (tx_start) starts_seen++;
    check("tx_start", tx_start, m_start);
    check("tx_uflow", tx_uflow, m_uf);
    check("tx_susp", tx_susp, (m_ph == 3) ? 1 : 0);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_frame();
    frm_bytes = '0; frm_eof_in = 0; eof_done = 1;
    tick();
    eof_done = 0;
    tick();
  endtask

  // threshold ramp: at threshold nothing, one above starts once
  task automatic ramp(string req, bit slow, int sel);
    int thr = table_bytes(slow, sel);
    cur_req = req;
    mode_10m = slow; thr_sel = 2'(sel); sf_en = 0;
    starts_seen = 0;
    frm_bytes = LEN_W'(thr);
    ticks(3);
    check("no start at threshold (R4)", starts_seen, 0);
    frm_bytes = LEN_W'(thr + 1);
    ticks(3);
    check("one start above threshold (R7)", starts_seen, 1);
    finish_frame();
  endtask

  initial begin
    rst_n = 0; frm_bytes = '0; frm_eof_in = 0; eof_done = 0; thr_sel = 2'd0;
    mode_10m = 0; sf_en = 0; fifo_empty = 0; uflow_clr = 0;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("reset tx_start", tx_start, 0);
    check("reset tx_uflow", tx_uflow, 0);
    check("reset tx_susp", tx_susp, 0);
    rst_n = 1;
    ticks(2);

    for (int s = 0; s < 4; s++) ramp("R2", 1'b0, s);
    for (int s = 0; s < 4; s++) ramp("R3", 1'b1, s);

    // R5: short complete frame
    cur_req = "R5"; starts_seen = 0;
    mode_10m = 0; thr_sel = 2'd3;
    frm_bytes = LEN_W'(40); frm_eof_in = 1;
    ticks(3);
    check("short frame starts", starts_seen, 1);
    finish_frame();

    // R6: store and forward ignores select
    cur_req = "R6"; starts_seen = 0;
    sf_en = 1; thr_sel = 2'd0; mode_10m = 1;
    frm_bytes = LEN_W'(2000);
    ticks(4);
    check("no start without eof", starts_seen, 0);
    frm_eof_in = 1;
    ticks(2);
    check("start on eof", starts_seen, 1);
    finish_frame();
    sf_en = 0;

    // R8: settings changed mid-frame keep captured values
    cur_req = "R8"; starts_seen = 0;
    mode_10m = 1; thr_sel = 2'd0;
    frm_bytes = LEN_W'(10);
    tick();
    mode_10m = 0; thr_sel = 2'd3; sf_en = 1;
    frm_bytes = LEN_W'(73);
    ticks(2);
    check("captured 72-byte threshold used", starts_seen, 1);
    sf_en = 0;
    finish_frame();

    // R7: held condition after start gives no second pulse until re-arm
    cur_req = "R7"; starts_seen = 0;
    frm_bytes = LEN_W'(600); thr_sel = 2'd1;
    ticks(6);
    check("single pulse while held", starts_seen, 1);
    finish_frame();

    // R9/R10/R11: underflow
    cur_req = "R9"; starts_seen = 0;
    frm_bytes = LEN_W'(300);
    ticks(2);
    fifo_empty = 1; frm_bytes = '0;
    tick();
    check("uflow raised", tx_uflow, 1);
    check("suspended", tx_susp, 1);
    fifo_empty = 0;
    cur_req = "R11";
    frm_bytes = LEN_W'(2000); frm_eof_in = 1;
    ticks(4);
    check("no start while suspended", starts_seen, 1);
    cur_req = "R10";
    check("uflow sticky", tx_uflow, 1);
    frm_bytes = '0; frm_eof_in = 0;
    uflow_clr = 1;
    tick();
    uflow_clr = 0;
    check("uflow cleared", tx_uflow, 0);
    check("suspension left", tx_susp, 0);
    frm_bytes = LEN_W'(20); frm_eof_in = 1;
    ticks(3);
    check("re-armed after clear", starts_seen, 2);
    finish_frame();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule